// File: doc/BRIEF.md
# Protected Output Fault Supervisor

This block sits between a controller and one switched industrial output driver. It gates the driver enable from a command line. It also watches four digital status lines from the driver: overcurrent/short, overtemperature, open-load sense and backfeed. Each wiring or load fault sets its own latched flag. The block records the cycle stamp of the first occurrence since the last clear and keeps a saturating count of occurrences, so every fault pattern can be read back and told apart.

The enable is a combinational function of the command and a registered permit. An output edge therefore follows the command in the same cycle, with no scheduling in between. An overcurrent, overtemperature or backfeed indication removes the enable in that same cycle. What happens next depends on a policy pin. In auto-retry mode the block waits a programmable cooldown and then retries, up to a programmable number of times. When the retries run out it stays off and raises a retry-exhausted flag. In latched mode the first trip keeps the output off until software pulses the clear input. A backfeed indication holds the output off until the command has been taken low once.

Every pin is a level-sampled control or status line. No data flows through the block, so it has no valid/ready handshake and no back-pressure. The configuration pins are expected to be held static while the output is in use.

Top module: `prot_out_sup`

## Requirements
- R1: While st_ocp or st_otp is high, drv_en is low in the same cycle. A rising edge of st_ocp sets fault_flags[0] (short) at the next clock edge.
- R2: When no fault or hold is active, drv_en equals cmd_on combinationally. There is no clock delay between a command edge and an enable edge.
- R3: The flag bits are fixed: fault_flags[0] is short, [1] is open-load, [2] is thermal and [3] is backfeed. A flag is set by its fault event and stays set until fault_clear. The short, thermal and backfeed events are rising edges of st_ocp, st_otp and st_bkfd. The open-load event is defined in R4. fault_ts slice i (bits i*TS_W upward) holds the value of a free-running cycle counter at the first event of fault i since the last clear. That counter reads 0 at the first clock edge after reset. fault_cnt slice i (bits i*CNT_W upward) counts fault i events, saturates at all ones, and is not affected by fault_clear.
- R4: The open-load event fires only after drv_en and st_open have both been high for cfg_open_qual consecutive cycles (cfg_open_qual at least 1). st_open is ignored while the output is off. A shorter assertion leaves the flag clear. Open-load does not remove the enable.
- R5: In auto-retry mode (policy_latch=0), a trip holds drv_en low for exactly cfg_cool clock cycles after the tripping cycle. The block then re-enables if cmd_on is high and no trip is present.
- R6: The block allows at most cfg_retry_max retries. The trip that follows the last allowed retry latches the output off and sets retry_exhausted.
- R7: The retry count returns to zero once the output has stayed on without a trip for more than cfg_stable cycles. After that, the full set of retries is available again.
- R8: In latched mode (policy_latch=1), the first trip keeps drv_en low for any length of time until fault_clear, and retry_exhausted stays low.
- R9: A fault_clear pulse clears all four flags and retry_exhausted, leaves the counters unchanged, and returns a latched output to the off state. The output then re-enables on cmd_on.
- R10: st_bkfd drops drv_en in the same cycle. After it goes away, drv_en stays low until cmd_on has been sampled low at a clock edge.
- R11: While rst_n is low, drv_en is low whatever cmd_on is. After reset, all flags, stamps and counters are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_on | input | 1 | Output command |
| policy_latch | input | 1 | 1 = latched-off policy, 0 = bounded auto-retry |
| fault_clear | input | 1 | One-cycle pulse clearing flags and latch |
| cfg_cool | input | TMR_W | Cooldown length in cycles |
| cfg_retry_max | input | RETRY_W | Number of retries allowed |
| cfg_stable | input | TMR_W | Fault-free on-time that resets the retry count |
| cfg_open_qual | input | TMR_W | Open-load qualification time in cycles |
| st_ocp | input | 1 | Driver overcurrent/short indication |
| st_otp | input | 1 | Driver overtemperature indication |
| st_open | input | 1 | Driver open-load sense |
| st_bkfd | input | 1 | Driver backfeed indication |
| drv_en | output | 1 | Driver enable |
| fault_flags | output | 4 | Latched flags: short, open, thermal, backfeed |
| retry_exhausted | output | 1 | Auto-retry budget used up |
| fault_ts | output | 4*TS_W | First-occurrence cycle stamp per fault |
| fault_cnt | output | 4*CNT_W | Saturating occurrence count per fault |

## Verification
On every cycle, the assertions check these rules. A fault event sets its flag and a clear removes it. A counter moves only on an event. Cooldown can only give way to a retry, and a latched state holds until cleared. The exhausted flag implies the latched state. An open-load flag rises only after the output was driven with the sense high. After a backfeed the enable stays off while the command is held. Some properties are visible only across a whole scenario, and only the bench's scenarios can show them. These are the exact cooldown length, the retry count that leads to exhaustion, the retry budget coming back after a stable on-period, the stamp values, and the rejection of short open-load pulses.

// File: rtl/pos_pkg.sv
package pos_pkg;
  localparam int NF       = 4;
  localparam int FI_SHORT = 0;
  localparam int FI_OPEN  = 1;
  localparam int FI_THERM = 2;
  localparam int FI_BKFD  = 3;

  typedef enum logic [2:0] {
    S_OFF,
    S_ON,
    S_COOL,
    S_RETRY,
    S_LATCH
  } sup_state_e;
endpackage

// File: rtl/pos_fault_log.sv
module pos_fault_log #(
  parameter int TS_W  = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  input  logic [TS_W-1:0]  ts_now,
  output logic             flag,
  output logic [TS_W-1:0]  ts,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      ts   <= '0;
      cnt  <= '0;
    end else begin
      if (evt) begin
        flag <= 1'b1;
        if (!flag || clr) ts <= ts_now;
        if (cnt != '1) cnt <= cnt + 1'b1;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end

  // R3: an event always leaves the flag set
  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  // R9: a clear without a new event empties the flag
  p_flag_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !flag);
  // R3: counter moves only on events (clear does not touch it)
  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(cnt));
endmodule

// File: rtl/pos_open_qual.sv
module pos_open_qual #(
  parameter int QW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          sense,
  input  logic [QW-1:0] qual,
  output logic          evt
);
  logic [QW-1:0] run;
  logic          cond;

  assign cond = active & sense;
  // fires once per qualified episode: run stops at qual
  assign evt  = cond && (run == qual - QW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           run <= '0;
    else if (!cond)       run <= '0;
    else if (run != qual) run <= run + 1'b1;
  end
endmodule

// File: rtl/pos_recovery_fsm.sv
module pos_recovery_fsm
  import pos_pkg::*;
#(
  parameter int TMR_W   = 16,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_on,
  input  logic               trip,
  input  logic               bkfd,
  input  logic               policy_latch,
  input  logic               clr,
  input  logic [TMR_W-1:0]   cfg_cool,
  input  logic [TMR_W-1:0]   cfg_stable,
  input  logic [RETRY_W-1:0] cfg_retry_max,
  output logic               permit,
  output logic               exhausted
);
  sup_state_e         state;
  logic [TMR_W-1:0]   tmr;
  logic [RETRY_W-1:0] retry;
  logic               bk_hold;
  logic               active;
  logic               cool_done;

  assign permit    = (state == S_OFF || state == S_ON || state == S_RETRY) && !bk_hold;
  assign active    = permit & cmd_on;
  assign cool_done = ({1'b0, tmr} + 1'b1) >= {1'b0, cfg_cool};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      tmr       <= '0;
      retry     <= '0;
      exhausted <= 1'b0;
      bk_hold   <= 1'b0;
    end else begin
      if (bkfd)         bk_hold <= 1'b1;
      else if (!cmd_on) bk_hold <= 1'b0;
      if (clr) exhausted <= 1'b0;
      case (state)
        S_OFF, S_ON, S_RETRY: begin
          if (active && trip) begin
            tmr <= '0;
            if (policy_latch) begin
              state <= S_LATCH;
            end else if (retry == cfg_retry_max) begin
              state     <= S_LATCH;
              exhausted <= 1'b1;
            end else begin
              state <= S_COOL;
              retry <= retry + 1'b1;
            end
          end else if (!cmd_on) begin
            state <= S_OFF;
          end else if (active) begin
            if (state != S_ON) begin
              state <= S_ON;
              tmr   <= '0;
            end else if (tmr != cfg_stable) begin
              tmr <= tmr + 1'b1;
            end else begin
              retry <= '0;
            end
          end
        end
        S_COOL: begin
          if (cool_done) begin
            state <= S_RETRY;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        S_LATCH: begin
          if (clr) begin
            state <= S_OFF;
            retry <= '0;
            tmr   <= '0;
          end
        end
        default: state <= S_OFF;
      endcase
    end
  end

  // R5: cooldown only ever gives way to a retry
  p_cool_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_COOL) |=> (state == S_COOL || state == S_RETRY));
  // R8: latched stays latched until cleared
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_LATCH && !clr) |=> (state == S_LATCH));
  // R6: exhausted flag only while latched off
  p_exh_latched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exhausted |-> (state == S_LATCH));
  // R6: retry count never exceeds the budget
  p_retry_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    retry <= cfg_retry_max);
endmodule

// File: rtl/prot_out_sup.sv
module prot_out_sup
  import pos_pkg::*;
#(
  parameter int TS_W    = 16,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 16,
  parameter int RETRY_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_on,
  input  logic               policy_latch,
  input  logic               fault_clear,
  input  logic [TMR_W-1:0]   cfg_cool,
  input  logic [RETRY_W-1:0] cfg_retry_max,
  input  logic [TMR_W-1:0]   cfg_stable,
  input  logic [TMR_W-1:0]   cfg_open_qual,
  input  logic               st_ocp,
  input  logic               st_otp,
  input  logic               st_open,
  input  logic               st_bkfd,
  output logic               drv_en,
  output logic [NF-1:0]      fault_flags,
  output logic               retry_exhausted,
  output logic [NF*TS_W-1:0] fault_ts,
  output logic [NF*CNT_W-1:0] fault_cnt
);
  logic [TS_W-1:0] ts_now;
  logic [NF-1:0]   raw_in, raw_q, evt;
  logic            permit;
  logic            open_evt;

  assign raw_in = {st_bkfd, st_otp, st_open, st_ocp};

  // fixed combinational path from command to enable
  assign drv_en = rst_n & cmd_on & permit & ~st_ocp & ~st_otp & ~st_bkfd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_now <= '0;
      raw_q  <= '0;
    end else begin
      ts_now <= ts_now + 1'b1;
      raw_q  <= raw_in;
    end
  end

  pos_recovery_fsm #(.TMR_W(TMR_W), .RETRY_W(RETRY_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_on       (cmd_on),
    .trip         (st_ocp | st_otp),
    .bkfd         (st_bkfd),
    .policy_latch (policy_latch),
    .clr          (fault_clear),
    .cfg_cool     (cfg_cool),
    .cfg_stable   (cfg_stable),
    .cfg_retry_max(cfg_retry_max),
    .permit       (permit),
    .exhausted    (retry_exhausted)
  );

  pos_open_qual #(.QW(TMR_W)) u_open (
    .clk   (clk),
    .rst_n (rst_n),
    .active(drv_en),
    .sense (st_open),
    .qual  (cfg_open_qual),
    .evt   (open_evt)
  );

  for (genvar g = 0; g < NF; g++) begin : g_log
    assign evt[g] = (g == FI_OPEN) ? open_evt : (raw_in[g] & ~raw_q[g]);
    pos_fault_log #(.TS_W(TS_W), .CNT_W(CNT_W)) u_log (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt[g]),
      .clr   (fault_clear),
      .ts_now(ts_now),
      .flag  (fault_flags[g]),
      .ts    (fault_ts[g*TS_W +: TS_W]),
      .cnt   (fault_cnt[g*CNT_W +: CNT_W])
    );
  end

  // R1: overcurrent rise always lands in the short flag
  p_short_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ocp) |=> fault_flags[FI_SHORT]);
  // R4: open flag rises only after driving with sense high
  p_open_qual_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_flags[FI_OPEN]) |-> $past(drv_en && st_open));
  // R10: backfeed with command held keeps enable off next cycle
  p_bkfd_rearm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_bkfd && cmd_on) |=> (!drv_en || !cmd_on));
endmodule

// File: tb/prot_out_sup_tb.sv
module prot_out_sup_tb;
  localparam int TS_W = 16, CNT_W = 8, TMR_W = 16, RETRY_W = 4, NF = 4;
  localparam int COOL = 4;

  // {cmd, ocp, otp, open, bkfd, expected drv_en}
  localparam logic [5:0] VEC [0:17] = '{
    6'b000000, 6'b100001, 6'b100001, 6'b110000,
    6'b100000, 6'b100000, 6'b100000, 6'b100000,
    6'b100001, 6'b101000,
    6'b100000, 6'b100000, 6'b100000, 6'b100000,
    6'b110000, 6'b100000, 6'b000000, 6'b100000
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_on = 0, policy_latch = 0, fault_clear = 0;
  logic st_ocp = 0, st_otp = 0, st_open = 0, st_bkfd = 0;
  logic drv_en, retry_exhausted;
  logic [NF-1:0] fault_flags;
  logic [NF*TS_W-1:0] fault_ts;
  logic [NF*CNT_W-1:0] fault_cnt;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  int ts_short, ts_therm, ts_open, ts_bk;

  always #10 clk = ~clk;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  prot_out_sup #(.TS_W(TS_W), .CNT_W(CNT_W), .TMR_W(TMR_W), .RETRY_W(RETRY_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_on(cmd_on), .policy_latch(policy_latch),
    .fault_clear(fault_clear), .cfg_cool(16'(COOL)), .cfg_retry_max(4'd2),
    .cfg_stable(16'd20), .cfg_open_qual(16'd3),
    .st_ocp(st_ocp), .st_otp(st_otp), .st_open(st_open), .st_bkfd(st_bkfd),
    .drv_en(drv_en), .fault_flags(fault_flags), .retry_exhausted(retry_exhausted),
    .fault_ts(fault_ts), .fault_cnt(fault_cnt)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, o, t, p, b, cl);
    @(negedge clk);
    cmd_on = c; st_ocp = o; st_otp = t; st_open = p; st_bkfd = b; fault_clear = cl;
    #2;
  endtask

  // trip then watch the cooldown and the retry (R5)
  task automatic trip_cool(input string tag);
    step(1, 1, 0, 0, 0, 0);
    chk({tag, " R1 drop on trip"}, int'(drv_en), 0);
    for (int k = 0; k < COOL; k++) begin
      step(1, 0, 0, 0, 0, 0);
      chk({tag, " R5 low during cooldown"}, int'(drv_en), 0);
    end
    step(1, 0, 0, 0, 0, 0);
    chk({tag, " R5 retry enables"}, int'(drv_en), 1);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R11: reset state, enable held low even with command high
    cmd_on = 1;
    repeat (3) @(negedge clk);
    #2;
    chk("R11 drv_en in reset", int'(drv_en), 0);
    chk("R11 flags in reset", int'(fault_flags), 0);
    chk("R11 counts in reset", int'(fault_cnt), 0);
    chk("R11 stamps in reset", int'(fault_ts[TS_W-1:0]), 0);
    cmd_on = 0;
    @(negedge clk); rst_n = 1;

    // table walk: R2 follow, R1 drop, R5 cooldown, R6 exhaustion
    for (int i = 0; i < 18; i++) begin
      step(VEC[i][5], VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], 0);
      if (i == 3) ts_short = cyc;
      if (i == 9) ts_therm = cyc;
      chk($sformatf("R2/R5/R6 vector %0d drv_en", i), int'(drv_en), int'(VEC[i][0]));
    end
    chk("R3 flags short+thermal", int'(fault_flags), 4'b0101);
    chk("R6 retry_exhausted", int'(retry_exhausted), 1);
    chk("R3 short stamp", int'(fault_ts[0*TS_W +: TS_W]), ts_short);
    chk("R3 thermal stamp", int'(fault_ts[2*TS_W +: TS_W]), ts_therm);
    chk("R3 short count", int'(fault_cnt[0*CNT_W +: CNT_W]), 2);
    chk("R3 thermal count", int'(fault_cnt[2*CNT_W +: CNT_W]), 1);

    // R9: clear
    step(0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R9 flags cleared", int'(fault_flags), 0);
    chk("R9 exhausted cleared", int'(retry_exhausted), 0);
    chk("R9 count kept", int'(fault_cnt[0*CNT_W +: CNT_W]), 2);
    step(1, 0, 0, 0, 0, 0);
    chk("R9 re-enable after clear", int'(drv_en), 1);

    // R4: open sense ignored while off
    for (int k = 0; k < 8; k++) step(0, 0, 0, 1, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    chk("R4 open ignored while off", int'(fault_flags[1]), 0);
    // R4: too short while on
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R4 short open pulse rejected", int'(fault_flags[1]), 0);
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0);
    step(1, 0, 0, 1, 0, 0);
    ts_open = cyc;
    chk("R4 open keeps enable", int'(drv_en), 1);
    step(1, 0, 0, 0, 0, 0);
    chk("R4 open flag qualified", int'(fault_flags[1]), 1);
    chk("R4 open count", int'(fault_cnt[1*CNT_W +: CNT_W]), 1);
    chk("R4 open stamp", int'(fault_ts[1*TS_W +: TS_W]), ts_open);

    // R10: backfeed hold and re-arm
    step(1, 0, 0, 0, 1, 0);
    ts_bk = cyc;
    chk("R10 backfeed drops enable", int'(drv_en), 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R10 held off after backfeed", int'(drv_en), 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0);
    chk("R10 re-armed after toggle", int'(drv_en), 1);
    chk("R3 backfeed flag", int'(fault_flags[3]), 1);
    chk("R3 backfeed stamp", int'(fault_ts[3*TS_W +: TS_W]), ts_bk);

    // R7: retry budget returns after stable on-time
    trip_cool("R7 first");
    trip_cool("R7 second");
    for (int k = 0; k < 30; k++) step(1, 0, 0, 0, 0, 0);
    trip_cool("R7 third");
    chk("R7 not exhausted after stable period", int'(retry_exhausted), 0);

    // R8: latched policy
    policy_latch = 1;
    step(1, 1, 0, 0, 0, 0);
    chk("R8 drop on trip", int'(drv_en), 0);
    for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 0, 0);
    chk("R8 stays latched", int'(drv_en), 0);
    chk("R8 no exhausted flag", int'(retry_exhausted), 0);
    step(0, 0, 0, 0, 0, 1);
    step(1, 0, 0, 0, 0, 0);
    chk("R8/R9 released by clear", int'(drv_en), 1);

    done = 1;
    finish_run();
  end
endmodule